// File: doc/BRIEF.md
# Non-Volatile Memory Command Sequencer

This block is the command front end for a small word-organised flash-style array, which it models internally as a register file of 16-bit words. Software starts an operation with three writes. First it writes one word into the array address space, which latches the target address and data. Next it writes an operation code into the command register. Last it writes 1 to the buffer-empty bit of the status register, which launches the command.

A one-deep command buffer sits between the sequence and the executor. A second sequence can therefore be staged and launched while the first command is still running.

Each operation lasts a fixed number of prescaler ticks. One tick is (divider + 1) clock cycles, where the divider is a value that software must write before it uses the array. Commands that reach protected sectors, as well as sequences written in the wrong order, stop with a sticky error flag. While a command is pending or running, array reads return zero.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 0xC0. A command starts only after three steps in order: an array write, a command write (register select 2), and a status write (register select 1) with bit 7 set. Once launched, bit 7 reads 0 until the executor accepts the command on the next clock.
- R2: Bit 6 (complete) is 1 only when no command is running and none is queued. After the executor takes a command, bit 7 returns to 1 while bit 6 stays 0, and a second sequence can be staged and launched during that time.
- R3: Writing 1 to status bit 5 (protection violation) or bit 4 (access error) clears that flag. Writes to bits 6 and 2 have no effect.
- R4: The operation codes are 0x05 erase verify, 0x20 word program, 0x40 sector erase, 0x41 mass erase and 0x60 sector modify. Any other code sets bit 4 and aborts the sequence.
- R5: When protection is enabled, protected sectors are those whose index (byte address bits 6:2) is at least `protSector`. Program, sector erase or sector modify aimed at a protected sector sets bit 5 and aborts. Mass erase sets bit 5 whenever protection is enabled.
- R6: An array write made before any divider write (register select 0) sets bit 4.
- R7: Erase sets words to 0xFFFF. Program ANDs the data into the addressed word. A sector is two words; sector erase and sector modify ignore byte address bits 1:0. Sector modify leaves the data in the lower word of the sector and 0xFFFF in the upper word.
- R8: Bit 2 (blank) clears when an erase verify starts. When the verify completes, bit 2 is set if every word is 0xFFFF and cleared otherwise. No other command changes bit 2.
- R9: `rdData` returns the word at `rdWord` while bit 6 is 1, and returns 0 while bit 6 is 0.
- R10: Bit 4 is set by any of: a program at an odd byte address, a command write with no staged array write, a launch with no staged command, or a second array write while a sequence is staged.
- R11: While bit 4 or bit 5 is set, array writes, command writes and launches are ignored.
- R12: With divider D, a command of N ticks (verify 1, program 2, sector erase 4, sector modify 6, mass erase 8) sets bit 6 exactly 1 + N*(D+1) clocks after its launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busArr | input | 1 | 1 selects the array space, 0 selects the registers |
| busAddr | input | 7 | Byte address in the array, or register select in bits 1:0 |
| busWData | input | 16 | Write data |
| protEnable | input | 1 | Enables sector protection |
| protSector | input | 5 | Lowest protected sector index |
| rdWord | input | 6 | Word index to read |
| rdData | output | 16 | Read data, gated by the complete flag |
| statusOut | output | 8 | Status byte {buffer empty, complete, protection violation, access error, 0, blank, 0, 0} |

## Verification
Every command code is run at several divider settings and at sector-aligned, mid-sector and odd addresses. The measured launch-to-complete latency shows whether the tick count and the divider are applied correctly. Programs laid over data already in the array distinguish an AND from an overwrite. Sector operations issued at a mid-sector address show whether alignment is enforced. Error cases use out-of-order and illegal writes, followed by a full sequence sent while a flag is still set, so that a leak of a blocked command shows up in array contents and status. Two sequences launched back to back separate the buffer-empty flag from the complete flag.

// File: rtl/nvm_cmd_pkg.sv
`timescale 1ns/1ps
package nvm_cmd_pkg;
  localparam logic [7:0] OP_VERIFY   = 8'h05;
  localparam logic [7:0] OP_PROG     = 8'h20;
  localparam logic [7:0] OP_SECERASE = 8'h40;
  localparam logic [7:0] OP_MASS     = 8'h41;
  localparam logic [7:0] OP_SECMOD   = 8'h60;

  localparam int BIT_CBE   = 7;
  localparam int BIT_CC    = 6;
  localparam int BIT_PV    = 5;
  localparam int BIT_AE    = 4;
  localparam int BIT_BLANK = 2;

  localparam logic [1:0] SEL_DIV  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_STAGED, SEQ_ARMED} seqState_t;

  typedef struct packed {
    logic ldDiv;
    logic ldStage;
    logic ldCmd;
    logic start;
    logic finish;
  } nvmStrobe_t;

  function automatic logic knownOp(input logic [7:0] op);
    return (op == OP_VERIFY) || (op == OP_PROG) || (op == OP_SECERASE) ||
           (op == OP_MASS) || (op == OP_SECMOD);
  endfunction
endpackage

// File: rtl/nvm_cmd_dp.sv
`timescale 1ns/1ps
module nvm_cmd_dp
  import nvm_cmd_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DIVW  = 6,
  localparam int AW   = $clog2(WORDS) + 1,
  localparam int WAW  = AW - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  nvmStrobe_t       str,
  input  logic [AW-1:0]    busAddr,
  input  logic [15:0]      busWData,
  input  logic [WAW-1:0]   rdWord,
  input  logic             rdEnable,
  output logic [DIVW-1:0]  divVal,
  output logic [AW-3:0]    stSec,
  output logic             stLsb,
  output logic [7:0]       stCmd,
  output logic [7:0]       exCmd,
  output logic             allBlank,
  output logic [15:0]      rdData
);
  logic [AW-1:0]  stAddr;
  logic [15:0]    stData;
  logic [WAW-1:0] exWord;
  logic [15:0]    exData;
  logic [15:0]    mem [WORDS];

  assign stSec = stAddr[AW-1:2];
  assign stLsb = stAddr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal <= '0;
      stAddr <= '0;
      stData <= '0;
      stCmd  <= '0;
      exWord <= '0;
      exData <= '0;
      exCmd  <= '0;
    end else begin
      if (str.ldDiv)   divVal <= busWData[DIVW-1:0];
      if (str.ldStage) begin
        stAddr <= busAddr;
        stData <= busWData;
      end
      if (str.ldCmd)   stCmd <= busWData[7:0];
      if (str.start) begin
        exWord <= stAddr[AW-1:1];
        exData <= stData;
        exCmd  <= stCmd;
      end
    end
  end

  // array update at command completion
  logic secOp;
  assign secOp = (exCmd == OP_SECERASE) || (exCmd == OP_SECMOD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (str.finish) begin
      for (int i = 0; i < WORDS; i++) begin
        if ((exCmd == OP_MASS) || (secOp && ((WAW-1)'(i >> 1) == exWord[WAW-1:1]))) begin
          mem[i] <= ((exCmd == OP_SECMOD) && (i % 2 == 0)) ? exData : 16'hFFFF;
        end else if ((exCmd == OP_PROG) && (WAW'(i) == exWord)) begin
          mem[i] <= mem[i] & exData;
        end
      end
    end
  end

  always_comb begin
    allBlank = 1'b1;
    for (int i = 0; i < WORDS; i++) begin
      if (mem[i] != 16'hFFFF) allBlank = 1'b0;
    end
  end

  assign rdData = rdEnable ? mem[rdWord] : 16'h0000;
endmodule

// File: rtl/nvm_cmd_ctl.sv
`timescale 1ns/1ps
module nvm_cmd_ctl
  import nvm_cmd_pkg::*;
#(
  parameter int AW         = 7,
  parameter int DIVW       = 6,
  parameter int T_VERIFY   = 1,
  parameter int T_PROG     = 2,
  parameter int T_SECERASE = 4,
  parameter int T_MASS     = 8,
  localparam int CW        = $clog2(T_MASS + T_SECERASE + T_PROG + T_VERIFY + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWr,
  input  logic            busArr,
  input  logic [1:0]      regSel,
  input  logic [7:0]      wByte,
  input  logic            protEnable,
  input  logic [AW-3:0]   protSector,
  input  logic [DIVW-1:0] divVal,
  input  logic [AW-3:0]   stSec,
  input  logic            stLsb,
  input  logic [7:0]      stCmd,
  input  logic [7:0]      exCmd,
  input  logic            allBlank,
  output nvmStrobe_t      str,
  output logic            rdEnable,
  output logic [7:0]      statusOut
);
  seqState_t      seq;
  logic           divSet, cbeEmpty, busy, accErr, protErr, blank;
  logic [DIVW-1:0] preCnt;
  logic [CW-1:0]  remain, nTicks;

  logic errAny, isArr, isStat, isCmd, isDiv;
  logic arrOk, arrBad, cmdBadAcc, cmdBadProt, cmdOk, launchReq, launchOk, launchBad;
  logic protHit, needProt;

  assign errAny = accErr | protErr;
  assign isArr  = busWr & busArr;
  assign isDiv  = busWr & ~busArr & (regSel == SEL_DIV);
  assign isStat = busWr & ~busArr & (regSel == SEL_STAT);
  assign isCmd  = busWr & ~busArr & (regSel == SEL_CMD);

  assign arrOk  = isArr & ~errAny & divSet & cbeEmpty & (seq == SEQ_IDLE);
  assign arrBad = isArr & ~errAny & ~arrOk;

  assign protHit  = protEnable & (stSec >= protSector);
  assign needProt = (wByte == OP_PROG) | (wByte == OP_SECERASE) | (wByte == OP_SECMOD);

  assign cmdBadAcc  = isCmd & ~errAny &
                      ((seq != SEQ_STAGED) | ~knownOp(wByte) | ((wByte == OP_PROG) & stLsb));
  assign cmdBadProt = isCmd & ~errAny & ~cmdBadAcc &
                      ((needProt & protHit) | ((wByte == OP_MASS) & protEnable));
  assign cmdOk      = isCmd & ~errAny & ~cmdBadAcc & ~cmdBadProt;

  assign launchReq = isStat & wByte[BIT_CBE] & ~errAny;
  assign launchOk  = launchReq & (seq == SEQ_ARMED);
  assign launchBad = launchReq & ~launchOk;

  always_comb begin
    case (stCmd)
      OP_PROG:     nTicks = CW'(T_PROG);
      OP_SECERASE: nTicks = CW'(T_SECERASE);
      OP_MASS:     nTicks = CW'(T_MASS);
      OP_SECMOD:   nTicks = CW'(T_SECERASE + T_PROG);
      default:     nTicks = CW'(T_VERIFY);
    endcase
  end

  always_comb begin
    str.ldDiv   = isDiv;
    str.ldStage = arrOk;
    str.ldCmd   = cmdOk;
    str.start   = ~cbeEmpty & ~busy;
    str.finish  = busy & (preCnt == divVal) & (remain == CW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq      <= SEQ_IDLE;
      divSet   <= 1'b0;
      cbeEmpty <= 1'b1;
      busy     <= 1'b0;
      accErr   <= 1'b0;
      protErr  <= 1'b0;
      blank    <= 1'b0;
      preCnt   <= '0;
      remain   <= '0;
    end else begin
      if (isDiv) divSet <= 1'b1;

      if (arrBad | cmdBadAcc | cmdBadProt | launchBad) seq <= SEQ_IDLE;
      else if (arrOk)    seq <= SEQ_STAGED;
      else if (cmdOk)    seq <= SEQ_ARMED;
      else if (launchOk) seq <= SEQ_IDLE;

      if (arrBad | cmdBadAcc | launchBad)   accErr <= 1'b1;
      else if (isStat & wByte[BIT_AE])      accErr <= 1'b0;

      if (cmdBadProt)                       protErr <= 1'b1;
      else if (isStat & wByte[BIT_PV])      protErr <= 1'b0;

      if (launchOk)       cbeEmpty <= 1'b0;
      else if (str.start) cbeEmpty <= 1'b1;

      if (str.start) begin
        busy   <= 1'b1;
        remain <= nTicks;
        preCnt <= '0;
      end else if (busy) begin
        if (preCnt == divVal) begin
          preCnt <= '0;
          if (remain == CW'(1)) busy <= 1'b0;
          else                  remain <= remain - CW'(1);
        end else begin
          preCnt <= preCnt + DIVW'(1);
        end
      end

      if (str.start && stCmd == OP_VERIFY)       blank <= 1'b0;
      else if (str.finish && exCmd == OP_VERIFY) blank <= allBlank;
    end
  end

  assign rdEnable  = cbeEmpty & ~busy;
  assign statusOut = {cbeEmpty, rdEnable, protErr, accErr, 1'b0, blank, 2'b00};
endmodule

// File: rtl/nvm_cmd_ctrl.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl
  import nvm_cmd_pkg::*;
#(
  parameter int WORDS      = 64,
  parameter int DIVW       = 6,
  parameter int T_VERIFY   = 1,
  parameter int T_PROG     = 2,
  parameter int T_SECERASE = 4,
  parameter int T_MASS     = 8,
  localparam int AW        = $clog2(WORDS) + 1,
  localparam int SECW      = AW - 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWr,
  input  logic            busArr,
  input  logic [AW-1:0]   busAddr,
  input  logic [15:0]     busWData,
  input  logic            protEnable,
  input  logic [SECW-1:0] protSector,
  input  logic [AW-2:0]   rdWord,
  output logic [15:0]     rdData,
  output logic [7:0]      statusOut
);
  nvmStrobe_t      str;
  logic [DIVW-1:0] divVal;
  logic [SECW-1:0] stSec;
  logic            stLsb, allBlank, rdEnable;
  logic [7:0]      stCmd, exCmd;

  nvm_cmd_ctl #(
    .AW(AW), .DIVW(DIVW), .T_VERIFY(T_VERIFY), .T_PROG(T_PROG),
    .T_SECERASE(T_SECERASE), .T_MASS(T_MASS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busArr(busArr),
    .regSel(busAddr[1:0]), .wByte(busWData[7:0]),
    .protEnable(protEnable), .protSector(protSector),
    .divVal(divVal), .stSec(stSec), .stLsb(stLsb), .stCmd(stCmd),
    .exCmd(exCmd), .allBlank(allBlank), .str(str),
    .rdEnable(rdEnable), .statusOut(statusOut)
  );

  nvm_cmd_dp #(.WORDS(WORDS), .DIVW(DIVW)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .busAddr(busAddr),
    .busWData(busWData), .rdWord(rdWord), .rdEnable(rdEnable),
    .divVal(divVal), .stSec(stSec), .stLsb(stLsb), .stCmd(stCmd),
    .exCmd(exCmd), .allBlank(allBlank), .rdData(rdData)
  );
endmodule

// File: rtl/nvm_cmd_chk.sv
`timescale 1ns/1ps
module nvm_cmd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic        busArr,
  input logic [1:0]  regSel,
  input logic [1:0]  clrBits,
  input logic        cbe,
  input logic        cc,
  input logic        pv,
  input logic        ae,
  input logic        blank,
  input logic [15:0] rdData
);
  // R2: complete is never reported while the buffer holds a command
  p_cc_needs_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    cc |-> cbe);

  // R3: write-one-to-clear on the access error flag
  p_clear_ae_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busArr && regSel == 2'd1 && clrBits[0] && ae) |=> !ae);

  // R3: write-one-to-clear on the protection flag
  p_clear_pv_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busArr && regSel == 2'd1 && clrBits[1] && pv) |=> !pv);

  // R9: no array data leaves the block while a command is pending
  p_read_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cc |-> (rdData == 16'h0000));

  // R11: a set error flag blocks any launch
  p_err_blocks_launch_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((ae || pv) && cbe) |=> cbe);

  // R8: blank only moves through a command
  p_blank_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cc && !busWr) |=> $stable(blank));
endmodule

bind nvm_cmd_ctrl nvm_cmd_chk u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busArr(busArr),
  .regSel(busAddr[1:0]), .clrBits(busWData[5:4]),
  .cbe(statusOut[7]), .cc(statusOut[6]), .pv(statusOut[5]),
  .ae(statusOut[4]), .blank(statusOut[2]), .rdData(rdData)
);

// File: tb/sim_nvm_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busArr = 1'b0, protEnable = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [15:0] busWData = '0;
  logic [4:0]  protSector = '0;
  logic [5:0]  rdWord = '0;
  logic [15:0] rdData;
  logic [7:0]  statusOut;

  int nChk = 0, nFail = 0, curDiv = 0;
  logic [15:0] model [64];
  logic blankExp = 1'b0;

  always #10 clk = ~clk;

  nvm_cmd_ctrl u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busArr(busArr), .busAddr(busAddr),
    .busWData(busWData), .protEnable(protEnable), .protSector(protSector),
    .rdWord(rdWord), .rdData(rdData), .statusOut(statusOut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic arr, input logic [6:0] a, input logic [15:0] d);
    busWr = 1'b1; busArr = arr; busAddr = a; busWData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  function automatic int ticksOf(input logic [7:0] op);
    case (op)
      8'h20: return 2;
      8'h40: return 4;
      8'h41: return 8;
      8'h60: return 6;
      default: return 1;
    endcase
  endfunction

  task automatic modelApply(input logic [7:0] op, input logic [6:0] a, input logic [15:0] d);
    case (op)
      8'h20: model[a[6:1]] = model[a[6:1]] & d;
      8'h40: begin model[{a[6:2], 1'b0}] = 16'hFFFF; model[{a[6:2], 1'b1}] = 16'hFFFF; end
      8'h60: begin model[{a[6:2], 1'b0}] = d; model[{a[6:2], 1'b1}] = 16'hFFFF; end
      8'h41: for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
      default: begin
        blankExp = 1'b1;
        for (int i = 0; i < 64; i++) if (model[i] != 16'hFFFF) blankExp = 1'b0;
      end
    endcase
  endtask

  task automatic setDiv(input int d);
    wr(1'b0, 7'd0, 16'(d));
    curDiv = d;
  endtask

  task automatic launch(input logic [6:0] a, input logic [15:0] d, input logic [7:0] op);
    wr(1'b1, a, d);
    wr(1'b0, 7'd2, {8'h00, op});
    wr(1'b0, 7'd1, 16'h0080);
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (!statusOut[6] && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runCmd(input logic [6:0] a, input logic [15:0] d, input logic [7:0] op);
    int n;
    launch(a, d, op);
    waitDone(n);
    chk("R12", $sformatf("latency op %h div %0d", op, curDiv), n, 1 + ticksOf(op) * (curDiv + 1));
    modelApply(op, a, d);
  endtask

  task automatic chkWord(input string req, input int w);
    rdWord = 6'(w);
    #1;
    chk(req, $sformatf("word %0d", w), rdData, model[w]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd7321));
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset status", statusOut, 8'hC0);

    // R6: array access before divider setup
    wr(1'b1, 7'd4, 16'h1111);
    chk("R6", "no divider", statusOut, 8'hD0);
    wr(1'b0, 7'd1, 16'h0010);
    chk("R3", "clear access error", statusOut, 8'hC0);

    setDiv(2);
    // R1 / R9: first program, observe the pending window
    launch(7'd4, 16'h1234, 8'h20);
    rdWord = 6'd2; #1;
    chk("R1", "buffer full after launch", statusOut, 8'h00);
    chk("R9", "read gated while pending", rdData, 16'h0000);
    waitDone(n);
    chk("R12", "program latency", n, 7);
    modelApply(8'h20, 7'd4, 16'h1234);
    chkWord("R1", 2);

    runCmd(7'd4, 16'hFF00, 8'h20);
    chkWord("R7", 2);                       // R7: AND gives 0x1200
    runCmd(7'd6, 16'hABCD, 8'h60);
    chkWord("R7", 2);
    chkWord("R7", 3);
    runCmd(7'd5, 16'h0000, 8'h40);
    chkWord("R7", 2);
    runCmd(7'd0, 16'h0000, 8'h41);
    runCmd(7'd0, 16'h0000, 8'h05);
    chk("R8", "verify on erased array", statusOut, 8'hC4);

    // R3: complete and blank ignore writes
    wr(1'b0, 7'd1, 16'h0000);
    chk("R3", "write zero keeps flags", statusOut, 8'hC4);
    wr(1'b0, 7'd1, 16'h0044);
    chk("R3", "write ones to read-only", statusOut, 8'hC4);

    runCmd(7'd0, 16'h0F0F, 8'h20);
    chk("R8", "blank held by program", statusOut, 8'hC4);
    runCmd(7'd0, 16'h0000, 8'h05);
    chk("R8", "verify on written array", statusOut, 8'hC0);

    // R4: unknown code, R11: blocked sequence during error
    wr(1'b1, 7'd20, 16'h0000);
    wr(1'b0, 7'd2, 16'h0033);
    chk("R4", "unknown code", statusOut, 8'hD0);
    launch(7'd20, 16'h0000, 8'h20);
    repeat (30) @(negedge clk);
    chk("R11", "status while blocked", statusOut, 8'hD0);
    chkWord("R11", 10);
    wr(1'b0, 7'd1, 16'h0010);

    // R10: ordering and alignment faults
    wr(1'b1, 7'd7, 16'h0000);
    wr(1'b0, 7'd2, 16'h0020);
    chk("R10", "odd program address", statusOut, 8'hD0);
    wr(1'b0, 7'd1, 16'h0010);
    wr(1'b0, 7'd1, 16'h0080);
    chk("R10", "launch with nothing staged", statusOut, 8'hD0);
    wr(1'b0, 7'd1, 16'h0010);
    wr(1'b0, 7'd2, 16'h0020);
    chk("R10", "command without array write", statusOut, 8'hD0);
    wr(1'b0, 7'd1, 16'h0010);
    wr(1'b1, 7'd8, 16'h0000);
    wr(1'b1, 7'd8, 16'h0000);
    chk("R10", "double array write", statusOut, 8'hD0);
    wr(1'b0, 7'd1, 16'h0010);
    chk("R3", "cleared again", statusOut, 8'hC0);

    // R5: protection
    protEnable = 1'b1; protSector = 5'd8;
    wr(1'b1, 7'd40, 16'h0000);
    wr(1'b0, 7'd2, 16'h0020);
    chk("R5", "program protected sector", statusOut, 8'hE0);
    launch(7'd40, 16'h0000, 8'h20);
    chk("R11", "launch ignored under violation", statusOut, 8'hE0);
    wr(1'b0, 7'd1, 16'h0020);
    chk("R3", "clear violation", statusOut, 8'hC0);
    wr(1'b1, 7'd0, 16'h0000);
    wr(1'b0, 7'd2, 16'h0041);
    chk("R5", "mass erase while protected", statusOut, 8'hE0);
    wr(1'b0, 7'd1, 16'h0020);
    chkWord("R5", 20);
    runCmd(7'd8, 16'h5A5A, 8'h20);
    chkWord("R5", 4);
    protEnable = 1'b0;

    // R2: queue a second command behind a running one
    launch(7'd10, 16'h00FF, 8'h20);
    chk("R2", "buffer full", statusOut, 8'h00);
    @(negedge clk);
    chk("R2", "buffer empty while running", statusOut, 8'h80);
    launch(7'd12, 16'hF0F0, 8'h20);
    chk("R2", "second command queued", statusOut, 8'h00);
    waitDone(n);
    modelApply(8'h20, 7'd10, 16'h00FF);
    modelApply(8'h20, 7'd12, 16'hF0F0);
    chkWord("R2", 5);
    chkWord("R2", 6);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int k;
      logic [7:0] op;
      logic [6:0] a;
      logic [15:0] d;
      setDiv($urandom_range(0, 3));
      k = $urandom_range(0, 9);
      op = (k == 0) ? 8'h41 : (k == 1) ? 8'h05 : (k < 5) ? 8'h60 : (k < 7) ? 8'h40 : 8'h20;
      a = (op == 8'h20) ? 7'($urandom_range(0, 63) * 2) : 7'($urandom_range(0, 127));
      d = 16'($urandom);
      runCmd(a, d, op);
      chk("R8", "status after random op", statusOut, {5'b11000, blankExp, 2'b00});
      chkWord("R7", int'(a[6:1]));
      chkWord("R7", $urandom_range(0, 63));
      chkWord("R9", $urandom_range(0, 63));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule